// File: doc/BRIEF.md
# Sequence-Numbered Sampling Link

This block joins one producer node and one consumer node through a single shared cell that is refreshed on the medium clock. The producer pulses a write strobe to place a new data word into the cell. Each write advances an 8-bit tag held next to the word. The consumer pulses a read strobe to copy the word out. With the word it records the tag it saw, which becomes its last-consumed number.

A freshness flag compares the two tags. It is true while the cell holds a tag the consumer has not yet taken. Neither strobe ever waits or is refused. A consumer that reads while the flag is false still receives the current word, and it is up to the consumer to test the flag first. All updates happen on medium-clock edges. Strobes are single-cycle pulses that are already synchronous to that clock.

Freshness is kept by a two-state machine, `LINK_STALE` and `LINK_FRESH`. Its transitions are:
- ARM: STALE to FRESH on a write.
- CONSUME: FRESH to STALE on a read alone.
- REFILL: to FRESH when a read and a write arrive together.
- ALIAS: to STALE when a write brings the tag round to the consumer's number.
- HOLD: no change otherwise.

Top module: `sampled_seq_link`

## Requirements
- R1: After reset, `fresh` is 0, `rd_data` is 0 and `rd_seq` is 0.
- R2: A write strobe with no read strobe, issued while `fresh` is 0, makes `fresh` 1 after that edge.
- R3: A read strobe with no write strobe, issued while `fresh` is 1, loads `rd_data` with the word of the most recent write and `rd_seq` with the number of writes so far modulo 256. `fresh` is 0 after that edge.
- R4: Each write advances the stored tag by exactly 1 modulo 256. When several writes precede a read, the read returns only the last word.
- R5: A read while `fresh` is 0 returns the word currently in the cell, leaves `rd_seq` unchanged and leaves `fresh` at 0.
- R6: When a read and a write strobe share an edge, the read returns the word and tag held before that edge, and `fresh` is 1 afterwards.
- R7: `fresh` equals the inequality of the stored tag and `rd_seq`. So 255 writes with no read leave `fresh` at 1, and exactly 256 writes with no read leave it at 0 (tag alias).
- R8: Without a read strobe, `rd_data` and `rd_seq` hold their values, and back-to-back strobes on consecutive edges are each taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Medium clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Producer write pulse |
| wr_data | input | DATA_W | Word to store |
| rd_stb | input | 1 | Consumer read pulse |
| rd_data | output | DATA_W | Last word sampled by the consumer |
| rd_seq | output | SEQ_W | Tag of the last sampled word |
| fresh | output | 1 | Unread data present in the cell |

## Verification
The assertions assume that strobes are sampled only at rising medium-clock edges and that no other agent changes the cell. They also assume a read and a write on the same edge are legal, and this case is covered by its own property. The stimulus changes every input on the falling edge and deasserts each strobe after one cycle, so every pulse is one cycle wide. Every combination of the two strobes is swept from both freshness states, a 256-write run exercises the tag alias, and a pseudo-random strobe stream follows.

// File: rtl/link_pkg.sv
package link_pkg;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_SEQ_W  = 8;

    typedef enum logic [0:0] {
        LINK_STALE = 1'b0,
        LINK_FRESH = 1'b1
    } link_state_e;
endpackage

// File: rtl/link_cell.sv
module link_cell #(
    parameter int DATA_W = 16,
    parameter int SEQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cell_data,
    output logic [SEQ_W-1:0]  cell_seq,
    output logic [SEQ_W-1:0]  cell_seq_nxt
);
    localparam logic [SEQ_W-1:0] SEQ_STEP = SEQ_W'(1);

    always_comb begin
        cell_seq_nxt = wr_stb ? cell_seq + SEQ_STEP : cell_seq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cell_data <= '0;
            cell_seq  <= '0;
        end else begin
            if (wr_stb) begin
                cell_data <= wr_data;
            end
            cell_seq <= cell_seq_nxt;
        end
    end
endmodule

// File: rtl/link_sampler.sv
module link_sampler #(
    parameter int DATA_W = 16,
    parameter int SEQ_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [DATA_W-1:0] cell_data,
    input  logic [SEQ_W-1:0]  cell_seq,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEQ_W-1:0]  rd_seq,
    output logic [SEQ_W-1:0]  rd_seq_nxt
);
    always_comb begin
        rd_seq_nxt = rd_stb ? cell_seq : rd_seq;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_seq  <= '0;
        end else begin
            if (rd_stb) begin
                rd_data <= cell_data;
            end
            rd_seq <= rd_seq_nxt;
        end
    end
endmodule

// File: rtl/link_fresh_fsm.sv
module link_fresh_fsm
    import link_pkg::*;
#(
    parameter int SEQ_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  logic             rd_stb,
    input  logic [SEQ_W-1:0] cell_seq_nxt,
    input  logic [SEQ_W-1:0] rd_seq_nxt,
    output logic             fresh
);
    link_state_e state_q, state_d;
    logic        tags_differ;

    assign tags_differ = (cell_seq_nxt != rd_seq_nxt);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LINK_STALE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LINK_STALE: begin
                if (wr_stb && tags_differ) begin
                    state_d = LINK_FRESH;          // ARM or REFILL
                end
            end
            LINK_FRESH: begin
                if (!tags_differ && (rd_stb || wr_stb)) begin
                    state_d = LINK_STALE;          // CONSUME or ALIAS
                end
            end
            default: state_d = LINK_STALE;
        endcase
    end

    always_comb begin
        fresh = (state_q == LINK_FRESH);
    end
endmodule

// File: rtl/sampled_seq_link.sv
module sampled_seq_link
    import link_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int SEQ_W  = DEF_SEQ_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data,
    output logic [SEQ_W-1:0]  rd_seq,
    output logic              fresh
);
    logic [DATA_W-1:0] cell_data;
    logic [SEQ_W-1:0]  cell_seq;
    logic [SEQ_W-1:0]  cell_seq_nxt;
    logic [SEQ_W-1:0]  rd_seq_nxt;

    link_cell #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_cell (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .wr_data      (wr_data),
        .cell_data    (cell_data),
        .cell_seq     (cell_seq),
        .cell_seq_nxt (cell_seq_nxt)
    );

    link_sampler #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_sampler (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_stb     (rd_stb),
        .cell_data  (cell_data),
        .cell_seq   (cell_seq),
        .rd_data    (rd_data),
        .rd_seq     (rd_seq),
        .rd_seq_nxt (rd_seq_nxt)
    );

    link_fresh_fsm #(.SEQ_W(SEQ_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .rd_stb       (rd_stb),
        .cell_seq_nxt (cell_seq_nxt),
        .rd_seq_nxt   (rd_seq_nxt),
        .fresh        (fresh)
    );
endmodule

// File: rtl/link_checker.sv
module link_checker #(
    parameter int DATA_W = 16,
    parameter int SEQ_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_stb,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input logic [SEQ_W-1:0]  rd_seq,
    input logic [SEQ_W-1:0]  cell_seq,
    input logic              fresh
);
    localparam logic [SEQ_W-1:0] SEQ_STEP = SEQ_W'(1);

    assert_arm_on_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !rd_stb && !fresh) |=> fresh);

    assert_consume_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !wr_stb) |=> !fresh);

    assert_tag_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (cell_seq == $past(cell_seq) + SEQ_STEP));

    assert_stale_read_keeps_tag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !fresh) |=> (rd_seq == $past(rd_seq)));

    assert_refill_fresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && wr_stb) |=> fresh);

    assert_fresh_tag_compare_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fresh == (cell_seq != rd_seq));

    assert_hold_without_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> ($stable(rd_data) && $stable(rd_seq)));
endmodule

bind sampled_seq_link link_checker #(.DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_link_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .rd_seq   (rd_seq),
    .cell_seq (cell_seq),
    .fresh    (fresh)
);

// File: tb/sampled_seq_link_test.sv
module sampled_seq_link_test;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 16;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_stb = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_stb = 1'b0;
    logic [DW-1:0] rd_data;
    logic [SW-1:0] rd_seq;
    logic          fresh;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    logic [DW-1:0] m_cell_d = '0;
    logic [SW-1:0] m_cell_s = '0;
    logic [DW-1:0] m_rd_d = '0;
    logic [SW-1:0] m_rd_s = '0;

    sampled_seq_link #(.DATA_W(DW), .SEQ_W(SW)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .rd_stb  (rd_stb),
        .rd_data (rd_data),
        .rd_seq  (rd_seq),
        .fresh   (fresh)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        logic exp_fresh;
        exp_fresh = (m_cell_s != m_rd_s);
        check(rd_data == m_rd_d, tag, "rd_data", int'(rd_data), int'(m_rd_d));
        check(rd_seq == m_rd_s, tag, "rd_seq", int'(rd_seq), int'(m_rd_s));
        check(fresh == exp_fresh, tag, "fresh", int'(fresh), int'(exp_fresh));
    endtask

    task automatic cyc(input logic w, input logic [DW-1:0] d, input logic r,
                       input string tag);
        wr_stb = w;
        wr_data = d;
        rd_stb = r;
        @(posedge clk);
        if (r) begin
            m_rd_d = m_cell_d;
            m_rd_s = m_cell_s;
        end
        if (w) begin
            m_cell_d = d;
            m_cell_s = m_cell_s + 8'd1;
        end
        @(negedge clk);
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        check_all(tag);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        summary();
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_all("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: arm on a write
        cyc(1'b1, 16'hA5C3, 1'b0, "R2");
        check(fresh == 1'b1, "R2", "fresh_after_write", int'(fresh), 1);
        // R3: consume
        cyc(1'b0, 16'h0000, 1'b1, "R3");
        check(rd_data == 16'hA5C3, "R3", "rd_data_word", int'(rd_data), 16'hA5C3);
        // R5: stale reads
        cyc(1'b0, 16'h0000, 1'b1, "R5");
        cyc(1'b0, 16'h0000, 1'b1, "R5");
        // R4: several writes, one read returns the last
        for (int i = 0; i < 5; i++) cyc(1'b1, 16'(16'h1000 + i), 1'b0, "R4");
        cyc(1'b0, 16'h0000, 1'b1, "R4");
        check(rd_data == 16'h1004, "R4", "last_word", int'(rd_data), 16'h1004);
        check(rd_seq == 8'd6, "R4", "tag_count", int'(rd_seq), 6);

        // R6: all strobe combinations from both freshness states
        for (int pre = 0; pre < 2; pre++) begin
            for (int combo = 0; combo < 4; combo++) begin
                cyc(1'b0, 16'h0000, 1'b1, "R5");
                if (pre == 1) cyc(1'b1, 16'(16'h2000 + combo), 1'b0, "R2");
                cyc(combo[0], 16'(16'h3000 + 16 * pre + combo), combo[1], "R6");
            end
        end

        // R8: idle and back-to-back strobes
        for (int i = 0; i < 4; i++) cyc(1'b0, 16'hFFFF, 1'b0, "R8");
        for (int i = 0; i < 6; i++) cyc(1'b1, 16'(16'h4000 + i), 1'b1, "R8");

        // R7: tag alias after 256 unread writes
        cyc(1'b0, 16'h0000, 1'b1, "R7");
        for (int i = 0; i < 255; i++) cyc(1'b1, 16'(16'h5000 + i), 1'b0, "R7");
        check(fresh == 1'b1, "R7", "fresh_after_255", int'(fresh), 1);
        cyc(1'b1, 16'h5EEE, 1'b0, "R7");
        check(fresh == 1'b0, "R7", "fresh_after_256", int'(fresh), 0);
        cyc(1'b0, 16'h0000, 1'b1, "R7");
        check(rd_data == 16'h5EEE, "R7", "aliased_word", int'(rd_data), 16'h5EEE);

        // R4: pseudo-random strobe stream
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(lfsr[0], lfsr ^ 16'h5A5A, lfsr[3] & lfsr[1], "R4");
        end

        summary();
    end
endmodule